// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM. After a reset it runs the fixed start-up routine that the memory needs before it accepts normal traffic. First it waits through a long settling pause. During the pause the command pins show a no-operation, clock enable is high and the data masks are high, so nothing drives the data bus. It then closes every bank with a precharge-all command. Next it loads the mode register from a value supplied on `mode_i`. After the mode-register recovery gap it issues a fixed number of auto-refresh commands, each followed by the refresh cycle time. When the last refresh has completed its wait, it raises `init_done` and holds it.

Every delay is a parameter counted in clock cycles. A system integrator sets `T_PAUSE` to the start-up pause time (at least 200 µs) divided by the clock period. `T_RP`, `T_RSC` and `T_RC` are set the same way from the memory's timing figures. Once `init_done` is high, the main memory controller takes over the command pins. Asserting reset again restarts the whole routine from the pause.

Top module: `sdram_init_seq`

## Requirements
- R1: NOP is the command code {cs_n,ras_n,cas_n,we_n} = 0111. From reset, and for the first T_PAUSE clock edges after reset is released, the command pins show only NOP. The first other command appears right after the T_PAUSE-th edge.
- R2: sd_cke is 1 in every cycle, including while reset is asserted.
- R3: All bits of sd_dqm are 1 from reset until init_done goes high.
- R4: The first command after the pause is precharge-all. Its code is 0010 (cs_n, ras_n and we_n low, cas_n high), with address bit AP_BIT (default 10) high.
- R5: Exactly T_RP cycles after precharge-all, the block issues the mode register set. Its code is 0000, sd_addr equals mode_i and sd_ba is 0.
- R6: Only NOP is issued after the mode register set until T_RSC cycles have passed. The first auto-refresh follows exactly T_RSC cycles after it.
- R7: Exactly N_REF auto-refresh commands (default 8) are issued, with code 0001 (we_n high, the rest low). Consecutive refreshes are exactly T_RC cycles apart.
- R8: init_done rises exactly T_RC cycles after the last refresh. It then stays high, with only NOP on the command pins, until reset.
- R9: With RELEASE_DQM=1 (default), sd_dqm is all zeros whenever init_done is high.
- R10: Asserting reset at any point drops init_done and returns the pins to the pause state (NOP, masks high). Releasing reset then runs the full sequence again from its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | ADDR_W | Value loaded into the mode register |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | DQM_W | Data byte masks |
| sd_addr | output | ADDR_W | Address pins |
| sd_ba | output | BANK_W | Bank select pins |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
All pins are decoded from registered state. Each command therefore becomes visible right after the clock edge on which its wait expires: precharge-all after the T_PAUSE-th edge following reset release, the mode set T_RP edges later, the first refresh T_RSC edges after that, each further refresh T_RC edges apart, and `init_done` T_RC edges after the last refresh. The bench counts rising edges between commands and samples the pins on the falling edge that follows each rising edge. It compares each measured gap with the expected distance. Reset is checked by sampling on the falling edge after reset is asserted, because the reset acts asynchronously.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [2:0] {
      ST_PAUSE,
      ST_PRECH,
      ST_WAIT_RP,
      ST_MODE,
      ST_WAIT_RSC,
      ST_REFR,
      ST_WAIT_RC,
      ST_READY
   } init_state_e;

   // bit order: cs_n, ras_n, cas_n, we_n
   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sd_cmd_t;

   localparam sd_cmd_t CMD_NOP   = 4'b0111;
   localparam sd_cmd_t CMD_PRECH = 4'b0010;
   localparam sd_cmd_t CMD_MODE  = 4'b0000;
   localparam sd_cmd_t CMD_REFR  = 4'b0001;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= W'(RST_VAL);
      else if (load_i)
         cnt_q <= val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
   import sdram_init_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BANK_W = 2,
   parameter int AP_BIT = 10
) (
   input  init_state_e       st_i,
   input  logic [ADDR_W-1:0] mode_i,
   output sd_cmd_t           cmd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BANK_W-1:0] ba_o
);

   localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

   always_comb begin
      cmd_o  = CMD_NOP;
      addr_o = '0;
      ba_o   = '0;
      unique case (st_i)
         ST_PRECH: begin
            cmd_o  = CMD_PRECH;
            addr_o = ALL_BANKS;
         end
         ST_MODE: begin
            cmd_o  = CMD_MODE;
            addr_o = mode_i;
         end
         ST_REFR:  cmd_o = CMD_REFR;
         default:  cmd_o = CMD_NOP;
      endcase
   end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int T_PAUSE     = 40000,
   parameter int T_RP        = 4,
   parameter int T_RSC       = 2,
   parameter int T_RC        = 14,
   parameter int N_REF       = 8,
   parameter int ADDR_W      = 13,
   parameter int BANK_W      = 2,
   parameter int DQM_W       = 2,
   parameter int AP_BIT      = 10,
   parameter bit RELEASE_DQM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] mode_i,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic              sd_cke,
   output logic [DQM_W-1:0]  sd_dqm,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [BANK_W-1:0] sd_ba,
   output logic              init_done
);

   localparam int T_A   = (T_RP > T_RSC) ? T_RP : T_RSC;
   localparam int T_B   = (T_A > T_RC) ? T_A : T_RC;
   localparam int T_MAX = (T_PAUSE > T_B) ? T_PAUSE : T_B;
   localparam int CNT_W = $clog2(T_MAX + 1);
   localparam int REF_W = $clog2(N_REF + 1);

   localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 2);
   localparam logic [CNT_W-1:0] RSC_LD = CNT_W'(T_RSC - 2);
   localparam logic [CNT_W-1:0] RC_LD  = CNT_W'(T_RC - 2);

   // elaboration-time parameter checks
   if (T_PAUSE < 1) begin : g_bad_pause
      $error("T_PAUSE must be at least 1");
   end
   if (T_RP < 2 || T_RSC < 2 || T_RC < 2) begin : g_bad_gap
      $error("T_RP, T_RSC and T_RC must each be at least 2");
   end
   if (N_REF < 1) begin : g_bad_ref
      $error("N_REF must be at least 1");
   end
   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must lie inside the address bus");
   end

   init_state_e      st_q, st_d;
   logic             tmr_load, tmr_zero, ref_inc;
   logic [CNT_W-1:0] tmr_val;
   logic [REF_W-1:0] ref_q;
   sd_cmd_t          cmd;

   sdram_init_timer #(
      .W       (CNT_W),
      .RST_VAL (T_PAUSE - 1)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      ref_inc  = 1'b0;
      unique case (st_q)
         ST_PAUSE:    if (tmr_zero) st_d = ST_PRECH;
         ST_PRECH: begin
            tmr_load = 1'b1;
            tmr_val  = RP_LD;
            st_d     = ST_WAIT_RP;
         end
         ST_WAIT_RP:  if (tmr_zero) st_d = ST_MODE;
         ST_MODE: begin
            tmr_load = 1'b1;
            tmr_val  = RSC_LD;
            st_d     = ST_WAIT_RSC;
         end
         ST_WAIT_RSC: if (tmr_zero) st_d = ST_REFR;
         ST_REFR: begin
            tmr_load = 1'b1;
            tmr_val  = RC_LD;
            ref_inc  = 1'b1;
            st_d     = ST_WAIT_RC;
         end
         ST_WAIT_RC:
            if (tmr_zero)
               st_d = (ref_q == REF_W'(N_REF)) ? ST_READY : ST_REFR;
         ST_READY:    st_d = ST_READY;
         default:     st_d = ST_PAUSE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_PAUSE;
         ref_q <= '0;
      end else begin
         st_q <= st_d;
         if (ref_inc) ref_q <= ref_q + 1'b1;
      end
   end

   sdram_init_cmd_enc #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W),
      .AP_BIT (AP_BIT)
   ) u_enc (
      .st_i   (st_q),
      .mode_i (mode_i),
      .cmd_o  (cmd),
      .addr_o (sd_addr),
      .ba_o   (sd_ba)
   );

   assign sd_cs_n   = cmd.cs_n;
   assign sd_ras_n  = cmd.ras_n;
   assign sd_cas_n  = cmd.cas_n;
   assign sd_we_n   = cmd.we_n;
   assign sd_cke    = 1'b1;
   assign init_done = (st_q == ST_READY);

   if (RELEASE_DQM) begin : g_dqm_release
      assign sd_dqm = init_done ? '0 : '1;
   end else begin : g_dqm_hold
      assign sd_dqm = '1;
   end

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
   import sdram_init_pkg::*;
#(
   parameter int T_PAUSE     = 40000,
   parameter int N_REF       = 8,
   parameter int ADDR_W      = 13,
   parameter int BANK_W      = 2,
   parameter int DQM_W       = 2,
   parameter int AP_BIT      = 10,
   parameter bit RELEASE_DQM = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mode_i,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [DQM_W-1:0]  dqm,
   input logic [ADDR_W-1:0] addr,
   input logic [BANK_W-1:0] ba,
   input logic              done
);

   localparam int PW = $clog2(T_PAUSE + 1);
   localparam int RW = $clog2(N_REF + 2);

   sd_cmd_t       cmd;
   logic [PW-1:0] since_rst;
   logic [RW-1:0] refs_seen;

   assign cmd = {cs_n, ras_n, cas_n, we_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= '0;
         refs_seen <= '0;
      end else begin
         if (since_rst != PW'(T_PAUSE)) since_rst <= since_rst + 1'b1;
         if (cmd == CMD_REFR) refs_seen <= refs_seen + 1'b1;
      end
   end

   // R1
   pause_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP) |-> (since_rst == PW'(T_PAUSE)));

   // R3
   dqm_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (dqm == '1));

   // R4
   prech_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRECH) |-> addr[AP_BIT]);

   // R5
   mode_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_MODE) |-> (addr == mode_i && ba == '0));

   // R6
   mode_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_MODE) |=> (cmd == CMD_NOP));

   // R7
   ref_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (refs_seen == RW'(N_REF)));

   // R8
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cmd == CMD_NOP));

   // R9
   dqm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (RELEASE_DQM && done) |-> (dqm == '0));

endmodule

bind sdram_init_seq sdram_init_chk #(
   .T_PAUSE     (T_PAUSE),
   .N_REF       (N_REF),
   .ADDR_W      (ADDR_W),
   .BANK_W      (BANK_W),
   .DQM_W       (DQM_W),
   .AP_BIT      (AP_BIT),
   .RELEASE_DQM (RELEASE_DQM)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mode_i (mode_i),
   .cs_n   (sd_cs_n),
   .ras_n  (sd_ras_n),
   .cas_n  (sd_cas_n),
   .we_n   (sd_we_n),
   .dqm    (sd_dqm),
   .addr   (sd_addr),
   .ba     (sd_ba),
   .done   (init_done)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;

   localparam int T_PAUSE = 60;
   localparam int T_RP    = 3;
   localparam int T_RSC   = 2;
   localparam int T_RC    = 7;
   localparam int N_REF   = 8;
   localparam int ADDR_W  = 13;
   localparam int BANK_W  = 2;
   localparam int DQM_W   = 2;
   localparam int N_STEP  = N_REF + 3;

   localparam logic [3:0] C_NOP  = 4'b0111;
   localparam logic [3:0] C_PRE  = 4'b0010;
   localparam logic [3:0] C_MRS  = 4'b0000;
   localparam logic [3:0] C_REF  = 4'b0001;
   localparam logic [3:0] C_DONE = 4'b1111;

   localparam logic [3:0] STEP_CODE [N_STEP] = '{
      C_PRE, C_MRS, C_REF, C_REF, C_REF, C_REF, C_REF, C_REF, C_REF, C_REF, C_DONE};
   localparam int STEP_GAP [N_STEP] = '{
      T_PAUSE, T_RP, T_RSC, T_RC, T_RC, T_RC, T_RC, T_RC, T_RC, T_RC, T_RC};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] mode = 13'h0232;
   logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, init_done;
   logic [DQM_W-1:0]  sd_dqm;
   logic [ADDR_W-1:0] sd_addr;
   logic [BANK_W-1:0] sd_ba;

   int n_chk = 0;
   int n_err = 0;
   int bad_cke = 0;
   int bad_dqm = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   sdram_init_seq #(
      .T_PAUSE (T_PAUSE), .T_RP (T_RP), .T_RSC (T_RSC), .T_RC (T_RC),
      .N_REF (N_REF), .ADDR_W (ADDR_W), .BANK_W (BANK_W), .DQM_W (DQM_W)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .mode_i (mode),
      .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n),
      .sd_we_n (sd_we_n), .sd_cke (sd_cke), .sd_dqm (sd_dqm),
      .sd_addr (sd_addr), .sd_ba (sd_ba), .init_done (init_done)
   );

   wire [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   // per-cycle pin monitor for R2 and R3
   always @(negedge clk) begin
      if (!sd_cke) bad_cke++;
      if (!init_done && sd_dqm != '1) bad_dqm++;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         $display("FAIL watchdog expired: got %0d cycles expected at most 100000", cycles);
         $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_event(output logic [3:0] code, output int gap);
      gap = 0;
      do begin
         @(posedge clk);
         gap++;
         @(negedge clk);
      end while (cmd == C_NOP && !init_done && gap < 5000);
      code = init_done ? C_DONE : cmd;
   endtask

   function automatic string step_req(input int i);
      if (i == 0) return "R1";
      if (i == 1) return "R5";
      if (i == 2) return "R6";
      if (i == N_STEP - 1) return "R8";
      return "R7";
   endfunction

   // walk the expected command table for the first 'upto' steps
   task automatic run_table(input int upto);
      logic [3:0] code;
      int         gap;
      for (int i = 0; i < upto; i++) begin
         wait_event(code, gap);
         chk(code == STEP_CODE[i], (i == 0) ? "R4" : step_req(i), "command code",
             code, STEP_CODE[i]);
         chk(gap == STEP_GAP[i], step_req(i), "cycles since previous event",
             gap, STEP_GAP[i]);
         if (STEP_CODE[i] == C_PRE)
            chk(sd_addr[10] == 1'b1, "R4", "precharge-all A10", sd_addr[10], 1);
         if (STEP_CODE[i] == C_MRS) begin
            chk(sd_addr == mode, "R5", "mode value on address", sd_addr, mode);
            chk(sd_ba == '0, "R5", "bank during mode set", sd_ba, 0);
         end
      end
   endtask

   initial begin
      // reset state
      repeat (3) @(negedge clk);
      chk(cmd == C_NOP, "R1", "command in reset", cmd, C_NOP);
      chk(sd_cke == 1'b1, "R2", "cke in reset", sd_cke, 1);
      chk(sd_dqm == '1, "R3", "dqm in reset", sd_dqm, 3);
      chk(init_done == 1'b0, "R10", "done in reset", init_done, 0);

      // full sequence, first mode value
      rst_n = 1'b1;
      run_table(N_STEP);
      repeat (20) @(negedge clk);
      chk(init_done == 1'b1, "R8", "done held", init_done, 1);
      chk(cmd == C_NOP, "R8", "command after done", cmd, C_NOP);
      chk(sd_dqm == '0, "R9", "dqm released after done", sd_dqm, 0);

      // reset during the pause, then full run with another mode value
      rst_n = 1'b0;
      @(negedge clk);
      chk(init_done == 1'b0, "R10", "done cleared by reset", init_done, 0);
      chk(sd_dqm == '1, "R10", "dqm back high in reset", sd_dqm, 3);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(cmd == C_NOP, "R10", "command after reset in pause", cmd, C_NOP);
      mode  = 13'h0027;
      rst_n = 1'b1;
      run_table(N_STEP);

      // reset in the middle of the refresh series
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      run_table(5);
      rst_n = 1'b0;
      @(negedge clk);
      chk(cmd == C_NOP, "R10", "command after reset in refresh", cmd, C_NOP);
      chk(init_done == 1'b0, "R10", "done after reset in refresh", init_done, 0);
      mode  = 13'h1A5C;
      rst_n = 1'b1;
      run_table(N_STEP);

      chk(bad_cke == 0, "R2", "cycles with cke low", bad_cke, 0);
      chk(bad_dqm == 0, "R3", "masked cycles with dqm low", bad_dqm, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule